// File: doc/BRIEF.md
# Indirect Table Access Port

This block lets software reach a set of internal lookup tables through two 64-bit registers instead of giving every table its own address range. One register, the pointer register, names a table, an entry inside it and whether the entry pointer should step forward on its own. The second register, the data window, reads or writes the entry that the pointer register currently names.

Each table has its own depth, which is a power of two. On every data-window access the stored index is first trimmed to the selected table's depth. When stepping is enabled, the index then moves to the next entry and wraps inside that depth. The resulting index is written back into the pointer register, so software can stream through a table with back-to-back data accesses.

Six tables have storage. Eight further select codes are accepted but have no storage behind them. Any other select code is rejected and raises an error pulse. Writes to the window-decode table raise a one-hot strobe for the entry that was written, so that neighbouring logic can re-evaluate that window.

Top module: `idx_table_port`

## Requirements
- R1: After reset the pointer register reads as zero, `rsp_valid`, `sel_err` and every bit of `win_upd` are low, and `req_ready` is high.
- R2: The pointer register sits at byte offset 0x00. Its index field is bits [8:0], its table select is bits [20:16] and its step-enable flag is bit 31. All other bits read as zero, and a write followed by a read returns only those fields.
- R3: The data window sits at byte offset 0x08. A write through it to a backed table is returned unchanged by a later read of the same table and entry. Entries with the same index in different tables are separate.
- R4: The table selects and depths are: 0 list (8 entries), 1 interrupt vector (8), 8 translation (512), 11 window decode (16), 12 domain (256) and 13 error vector (4). Before use, the index is ANDed with the depth minus one, and the trimmed index is stored back.
- R5: With the step flag set, every data-window access, whether a read or a write, leaves the stored index at (trimmed index + 1) AND (depth − 1). The wrap happens inside the selected table.
- R6: Selects 2 and 3 (mask 31), 4, 9 and 10 (mask 63), 5 (mask 7), and 6 and 7 (mask 255) have no storage. Data reads of these selects return zero and data writes are dropped. Index trimming and stepping still apply.
- R7: Selects 14 to 31 are unknown. A data-window access with such a select leaves the pointer register unchanged, returns zero on a read and pulses `sel_err` high for one cycle, in the cycle after the request.
- R8: A write to the interrupt-vector table keeps only bits [27:0] of the written value: server in [23:8], priority in [7:0] and node in [27:24]. The other bits are stored as zero.
- R9: A write to window-decode entry n raises `win_upd[n]`, and only that bit, for exactly the cycle after the request. Reads, and writes to any other table, leave `win_upd` at zero.
- R10: Every read request is answered with `rsp_valid` high and the data on `rsp_rdata` in the cycle after it is accepted. Writes produce no response pulse.
- R11: Reads at any byte offset other than 0x00 and 0x08 return zero. Writes at such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| win_upd | output | WIN_N | One-hot strobe for a written window-decode entry |
| sel_err | output | 1 | Data access with an unknown table select |

## Verification
The hardest case to reach is wrapping in the deepest table. Reaching it by stepping from entry zero would take hundreds of accesses. The bench instead loads the pointer register with the last two entries and the step flag set, then streams three accesses so the index crosses from 511 to 0. The entries are read back the same way. Trimming is exercised by loading index values larger than the selected table's depth and reading the pointer register back after each access.

// File: rtl/idx_table_port.sv
module idx_table_port #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 9,
  parameter int SEL_W  = 5,
  parameter int LIST_N = 8,
  parameter int IVEC_N = 8,
  parameter int XLAT_N = 512,
  parameter int WIN_N  = 16,
  parameter int DOM_N  = 256,
  parameter int ERRV_N = 4,
  parameter logic [63:0] IVEC_KEEP = 64'h0000_0000_0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [WIN_N-1:0]  win_upd,
  output logic              sel_err
);
  localparam logic [ADDR_W-1:0] OFF_PTR = '0;
  localparam logic [ADDR_W-1:0] OFF_DAT = ADDR_W'(8);
  localparam int STEP_BIT = 31;
  localparam int SEL_LSB  = 16;
  localparam int LIST_AW = $clog2(LIST_N);
  localparam int IVEC_AW = $clog2(IVEC_N);
  localparam int XLAT_AW = $clog2(XLAT_N);
  localparam int WIN_AW  = $clog2(WIN_N);
  localparam int DOM_AW  = $clog2(DOM_N);
  localparam int ERRV_AW = $clog2(ERRV_N);

  localparam logic [SEL_W-1:0] T_LIST = 0, T_IVEC = 1, T_CACHE0 = 2, T_CACHE1 = 3,
    T_CAM0 = 4, T_MAP = 5, T_STATE0 = 6, T_STATE1 = 7, T_XLAT = 8, T_CAM1 = 9,
    T_CAM2 = 10, T_WIN = 11, T_DOM = 12, T_ERRV = 13;

  logic             step_q;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] idx_q, mask, idx_m, idx_nx;
  logic             known;
  logic [63:0]      tbl_rd, ptr_view;

  logic [63:0] list_m [LIST_N];
  logic [63:0] ivec_m [IVEC_N];
  logic [63:0] xlat_m [XLAT_N];
  logic [63:0] win_m  [WIN_N];
  logic [63:0] dom_m  [DOM_N];
  logic [63:0] errv_m [ERRV_N];

  assign req_ready = 1'b1;

  always_comb begin
    known = 1'b1;
    mask  = '0;
    case (sel_q)
      T_LIST:                   mask = IDX_W'(LIST_N - 1);
      T_IVEC:                   mask = IDX_W'(IVEC_N - 1);
      T_XLAT:                   mask = IDX_W'(XLAT_N - 1);
      T_WIN:                    mask = IDX_W'(WIN_N - 1);
      T_DOM:                    mask = IDX_W'(DOM_N - 1);
      T_ERRV:                   mask = IDX_W'(ERRV_N - 1);
      T_CACHE0, T_CACHE1:       mask = IDX_W'(31);
      T_CAM0, T_CAM1, T_CAM2:   mask = IDX_W'(63);
      T_MAP:                    mask = IDX_W'(7);
      T_STATE0, T_STATE1:       mask = IDX_W'(255);
      default:                  known = 1'b0;
    endcase
  end

  assign idx_m  = idx_q & mask;
  assign idx_nx = step_q ? ((idx_m + IDX_W'(1)) & mask) : idx_m;

  always_comb begin
    case (sel_q)
      T_LIST:  tbl_rd = list_m[idx_m[LIST_AW-1:0]];
      T_IVEC:  tbl_rd = ivec_m[idx_m[IVEC_AW-1:0]];
      T_XLAT:  tbl_rd = xlat_m[idx_m[XLAT_AW-1:0]];
      T_WIN:   tbl_rd = win_m[idx_m[WIN_AW-1:0]];
      T_DOM:   tbl_rd = dom_m[idx_m[DOM_AW-1:0]];
      T_ERRV:  tbl_rd = errv_m[idx_m[ERRV_AW-1:0]];
      default: tbl_rd = '0;
    endcase
  end

  always_comb begin
    ptr_view = '0;
    ptr_view[STEP_BIT] = step_q;
    ptr_view[SEL_LSB +: SEL_W] = sel_q;
    ptr_view[IDX_W-1:0] = idx_q;
  end

  logic hit_ptr, hit_dat, dacc, dwr;
  assign hit_ptr = req_valid && (req_addr == OFF_PTR);
  assign hit_dat = req_valid && (req_addr == OFF_DAT);
  assign dacc    = hit_dat && known;
  assign dwr     = dacc && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= 1'b0;
      sel_q     <= '0;
      idx_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      win_upd   <= '0;
      sel_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= hit_ptr ? ptr_view : (dacc ? tbl_rd : '0);
      sel_err   <= hit_dat && !known;
      win_upd   <= '0;
      if (dwr && sel_q == T_WIN) win_upd[idx_m[WIN_AW-1:0]] <= 1'b1;
      if (hit_ptr && req_write) begin
        step_q <= req_wdata[STEP_BIT];
        sel_q  <= req_wdata[SEL_LSB +: SEL_W];
        idx_q  <= req_wdata[IDX_W-1:0];
      end else if (dacc) begin
        idx_q <= idx_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dwr) begin
      case (sel_q)
        T_LIST:  list_m[idx_m[LIST_AW-1:0]] <= req_wdata;
        T_IVEC:  ivec_m[idx_m[IVEC_AW-1:0]] <= req_wdata & IVEC_KEEP;
        T_XLAT:  xlat_m[idx_m[XLAT_AW-1:0]] <= req_wdata;
        T_WIN:   win_m[idx_m[WIN_AW-1:0]]   <= req_wdata;
        T_DOM:   dom_m[idx_m[DOM_AW-1:0]]   <= req_wdata;
        T_ERRV:  errv_m[idx_m[ERRV_AW-1:0]] <= req_wdata;
        default: ;
      endcase
    end
  end

  assert_win_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_upd));
  assert_win_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_upd != '0) |-> $past(req_valid && req_write));
  assert_err_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (idx_q == $past(idx_q) && sel_q == $past(sel_q)));
  assert_err_from_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> $past(req_valid && req_addr == OFF_DAT));
  assert_read_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_write_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: tb/idx_table_port_tb.sv
module idx_table_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, sel_err;
  logic [63:0] rsp_rdata;
  logic [15:0] win_upd;
  int checks = 0, errs = 0;
  logic [15:0] l_win;
  logic l_err, l_rv;

  always #5 clk = ~clk;

  idx_table_port u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .win_upd(win_upd), .sel_err(sel_err));

  function automatic logic [63:0] ptr(input int sel, input int idx, input bit st);
    logic [63:0] v = '0;
    v[31] = st; v[20:16] = 5'(sel); v[8:0] = 9'(idx);
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
    l_win = win_upd; l_err = sel_err; l_rv = rsp_valid;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    d = rsp_rdata; l_win = win_upd; l_err = sel_err; l_rv = rsp_valid;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R1 win_upd", 64'(win_upd), 0);
    chk("R1 sel_err", 64'(sel_err), 0);
    chk("R1 ready", 64'(req_ready), 1);
    rd(12'h0, d); chk("R1 pointer", d, 0);
  endtask

  task automatic t_ptr_layout;
    logic [63:0] d;
    wr(12'h0, '1); rd(12'h0, d); chk("R2 fields only", d, 64'h0000_0000_801F_01FF);
  endtask

  task automatic t_backed;
    logic [63:0] d;
    int sels[6] = '{0, 1, 8, 11, 12, 13};
    foreach (sels[i]) begin
      wr(12'h0, ptr(sels[i], 2, 0)); wr(12'h8, 64'h0000_0000_0100_0000 + 64'(i));
    end
    foreach (sels[i]) begin
      wr(12'h0, ptr(sels[i], 2, 0)); rd(12'h8, d);
      chk("R3 readback", d, 64'h0000_0000_0100_0000 + 64'(i));
    end
  endtask

  task automatic t_mask;
    logic [63:0] d;
    wr(12'h0, ptr(0, 13, 0)); wr(12'h8, 64'hA5A5_0000_1111_2222);
    rd(12'h0, d); chk("R4 list trimmed", d, ptr(0, 5, 0));
    rd(12'h8, d); chk("R4 list entry 5", d, 64'hA5A5_0000_1111_2222);
    wr(12'h0, ptr(12, 511, 0)); wr(12'h8, 64'hD0D0);
    rd(12'h0, d); chk("R4 domain trimmed", d, ptr(12, 255, 0));
    wr(12'h0, ptr(13, 6, 0)); wr(12'h8, 64'hE6);
    wr(12'h0, ptr(13, 2, 0)); rd(12'h8, d); chk("R4 error vector alias", d, 64'hE6);
  endtask

  task automatic t_step;
    logic [63:0] d;
    wr(12'h0, ptr(8, 510, 1));
    for (int k = 0; k < 3; k++) wr(12'h8, 64'hBEEF_0000 + 64'(k));
    rd(12'h0, d); chk("R5 xlat wrap", d, ptr(8, 1, 1));
    wr(12'h0, ptr(8, 510, 1));
    for (int k = 0; k < 3; k++) begin
      rd(12'h8, d); chk("R5 stream read", d, 64'hBEEF_0000 + 64'(k));
    end
    rd(12'h0, d); chk("R5 read steps", d, ptr(8, 1, 1));
    wr(12'h0, ptr(13, 3, 1)); rd(12'h8, d);
    rd(12'h0, d); chk("R5 error vector wrap", d, ptr(13, 0, 1));
  endtask

  task automatic t_unbacked;
    logic [63:0] d;
    wr(12'h0, ptr(6, 300, 1)); wr(12'h8, 64'hFFFF);
    rd(12'h8, d); chk("R6 reads zero", d, 0);
    rd(12'h0, d); chk("R6 index steps", d, ptr(6, 46, 1));
    wr(12'h0, ptr(5, 7, 1)); rd(12'h8, d); chk("R6 map zero", d, 0);
    rd(12'h0, d); chk("R6 map wrap", d, ptr(5, 0, 1));
  endtask

  task automatic t_unknown;
    logic [63:0] d;
    wr(12'h0, ptr(20, 5, 1)); wr(12'h8, 64'h1234);
    chk("R7 error pulse", 64'(l_err), 1);
    @(negedge clk); chk("R7 pulse one cycle", 64'(sel_err), 0);
    rd(12'h0, d); chk("R7 pointer kept", d, ptr(20, 5, 1));
    rd(12'h8, d); chk("R7 read zero", d, 0); chk("R7 read err", 64'(l_err), 1);
    rd(12'h0, d); chk("R7 pointer kept after read", d, ptr(20, 5, 1));
  endtask

  task automatic t_ivec;
    logic [63:0] d;
    wr(12'h0, ptr(1, 4, 0)); wr(12'h8, '1); rd(12'h8, d);
    chk("R8 kept fields", d, 64'h0FFF_FFFF);
  endtask

  task automatic t_strobe;
    logic [63:0] d;
    wr(12'h0, ptr(11, 16'h1F3, 0)); wr(12'h8, 64'h77);
    chk("R9 strobe bit 3", 64'(l_win), 64'h8);
    @(negedge clk); chk("R9 strobe one cycle", 64'(win_upd), 0);
    rd(12'h0, d); chk("R9 win trimmed", d, ptr(11, 3, 0));
    rd(12'h8, d); chk("R9 read no strobe", 64'(l_win), 0);
    wr(12'h0, ptr(0, 3, 0)); wr(12'h8, 64'h1);
    chk("R9 other table no strobe", 64'(l_win), 0);
  endtask

  task automatic t_bus;
    logic [63:0] d;
    rd(12'h0, d); chk("R10 read rsp", 64'(l_rv), 1);
    wr(12'h0, ptr(0, 0, 0)); chk("R10 write no rsp", 64'(l_rv), 0);
    @(negedge clk); chk("R10 rsp single", 64'(rsp_valid), 0);
  endtask

  task automatic t_other;
    logic [63:0] d;
    wr(12'h0, ptr(12, 9, 1)); wr(12'h10, '1);
    rd(12'h10, d); chk("R11 other reads zero", d, 0);
    rd(12'h0, d); chk("R11 pointer unchanged", d, ptr(12, 9, 1));
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ptr_layout; t_backed; t_mask; t_step;
    t_unbacked; t_unknown; t_ivec; t_strobe; t_bus; t_other;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule